// File: doc/BRIEF.md
# Paged Serial Flash Command Front End

This block is the device side of a serial paged flash, seen from the host wire. The host lowers the select line and clocks an 8-bit command, a 24-bit address field and then data, most significant bit first, in SPI mode 0 or mode 3. The three host wires are brought into the system clock domain through synchronisers. A state machine decodes the command and, depending on it, does one of four things: streams bytes into one of two page-sized SRAM buffers; streams bytes out of a buffer, the flash array or the status byte; holds a self-timed array operation until the select line rises; or ignores the rest of the command. The flash array is modelled as a plain memory of `NUM_PAGES` pages of `PAGE_BYTES` bytes. A copy engine moves a whole page between the array and a buffer and stays busy for a configurable tail time after the copy.

Front-end states:
- `ST_IDLE`: select high.
- `ST_OPC`: command bits.
- `ST_ADDR`: address bits.
- `ST_DUMMY`: ignored bits before read data.
- `ST_OUT`: output streaming.
- `ST_IN`: input streaming.
- `ST_HOLD`: a self-timed command is complete and waits for select to rise.
- `ST_SKIP`: command rejected.

Transitions:
- Any state goes to `ST_IDLE` while select is high.
- `ST_IDLE` goes to `ST_OPC` once select is low.
- `ST_OPC` goes after its 8th bit to one of three states: `ST_OUT` for a status read, `ST_SKIP` for an unknown command or an array command while busy, and `ST_ADDR` otherwise.
- `ST_ADDR` goes after its 24th bit to one of three states: `ST_DUMMY` for reads, `ST_IN` for buffer writes, and `ST_HOLD` for copies.
- `ST_DUMMY` goes to `ST_OUT` after 32 bits (array read) or 8 bits (buffer read).
- When select rises in `ST_HOLD` with the engine idle, the engine is launched. The engine steps through `E_IDLE`, then `E_COPY`, then `E_TAIL`, and back to `E_IDLE`.

Top module: `pflash_frontend`

## Requirements
- R1: Command bits are sampled on rising SCK, MSB first, in both mode 0 (SCK idle low) and mode 3 (SCK idle high). A command byte outside 52h, 53h, 54h, 55h, 56h, 57h, 83h, 84h, 86h and 87h is ignored until select rises, and SO stays high impedance throughout.
- R2: Array read 52h takes a 24-bit field, which is 3 reserved bits, the page number in bits 20:9 and the byte offset in bits 8:0. It is followed by 32 ignored bits, and then the page bytes are shifted out MSB first.
- R3: Buffer reads (54h for buffer 0, 56h for buffer 1) take a 24-bit field with the offset in bits 8:0. After 8 ignored bits, the buffer bytes are shifted out.
- R4: Buffer writes (84h for buffer 0, 87h for buffer 1) take a 24-bit field with the offset in bits 8:0. Each complete received byte is stored at consecutive offsets. A partial byte at the rise of select is discarded.
- R5: Offsets advance from PAGE_BYTES-1 (263) back to 0 within the same buffer or page. A start offset of 264 or more is taken as offset minus 264.
- R6: Status read 57h shifts out a byte repeatedly for as long as SCK runs. Bit 7 is ready, bit 6 is 0, bits 5:3 are 100 and bits 2:0 are 000: A0h when idle and 20h when busy. Each repetition reflects the live ready value.
- R7: SO changes only after a falling SCK. SO is high impedance while select is high and during the command and address bits.
- R8: Page-to-buffer copy (53h into buffer 0, 55h into buffer 1; page in bits 20:9) starts when select rises. While it runs, `rdy` is low, and `rdy` returns high when it ends.
- R9: Buffer-to-page program (83h from buffer 0, 86h from buffer 1; page in bits 20:9) starts when select rises and replaces the whole page with the buffer contents.
- R10: While busy, the commands that use the array (52h, 53h, 55h, 83h, 86h) are rejected: no output and no launch. Buffer writes and reads still work.
- R11: After reset, `rdy` is high and SO is high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | Serial clock from host |
| csn | input | 1 | Active-low select from host |
| si | input | 1 | Serial data from host |
| so | output | 1 | Serial data to host, tri-state |
| rdy | output | 1 | High when no self-timed operation runs |

## Verification
The bench targets the following corner cases:
- **Offset wrap.** Reads and writes that cross offset 263 must continue at 0. A design that ran on would read unwritten bytes, and a design that mishandled start offsets past 263 would return the wrong byte.
- **Mode 3 and dummy lengths.** A mode 3 read checks that the leading falling edge is harmless. The two dummy lengths (32 and 8 bits) are both exercised; an off-by-one there shifts every data byte by a bit.
- **Partial write byte.** A trailing partial byte must leave the old buffer byte intact.
- **Commands while busy.** The bench issues a rejected array read, whose output must stay high impedance. It also issues a rejected copy, which would otherwise fill a buffer with an unwritten page.
- **Live status.** A long status read during busy must flip from 20h to A0h without reselecting.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_DUMMY, ST_OUT, ST_IN, ST_HOLD, ST_SKIP
    } fe_state_t;

    typedef enum logic [2:0] {
        K_NONE, K_ARD, K_BRD, K_BWR, K_STAT, K_XFER, K_PROG
    } cmd_kind_t;

    typedef struct packed {
        cmd_kind_t kind;
        logic      bsel;
    } cmd_t;

    function automatic cmd_t decode_op(input logic [7:0] op);
        cmd_t c;
        c.kind = K_NONE;
        c.bsel = 1'b0;
        case (op)
            8'h52: c.kind = K_ARD;
            8'h54: c.kind = K_BRD;
            8'h56: begin c.kind = K_BRD;  c.bsel = 1'b1; end
            8'h84: c.kind = K_BWR;
            8'h87: begin c.kind = K_BWR;  c.bsel = 1'b1; end
            8'h57: c.kind = K_STAT;
            8'h53: c.kind = K_XFER;
            8'h55: begin c.kind = K_XFER; c.bsel = 1'b1; end
            8'h83: c.kind = K_PROG;
            8'h86: begin c.kind = K_PROG; c.bsel = 1'b1; end
            default: c.kind = K_NONE;
        endcase
        return c;
    endfunction

    function automatic logic needs_array(input cmd_kind_t k);
        return (k == K_ARD) || (k == K_XFER) || (k == K_PROG);
    endfunction

    function automatic logic [7:0] status_byte(input logic ready);
        return {ready, 1'b0, 3'b100, 3'b000};
    endfunction

endpackage

// File: rtl/pflash_sync.sv
module pflash_sync #(
    parameter int         W         = 3,
    parameter int         STAGES    = 2,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], async_in[g]};
        end
        assign sync_out[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= RESET_VAL;
        else        prev <= sync_out;
    end

    assign rise = sync_out & ~prev;
    assign fall = ~sync_out & prev;
endmodule

// File: rtl/pflash_store.sv
module pflash_store #(
    parameter int PAGE_BYTES = 264,
    parameter int NUM_PAGES  = 8,
    parameter int PAGE_NUM_W = 12,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int AW        = $clog2(NUM_PAGES * PAGE_BYTES)
) (
    input  logic                  clk,
    input  logic                  hw_en,
    input  logic                  hw_sel,
    input  logic [OFF_W-1:0]      hw_off,
    input  logic [7:0]            hw_data,
    input  logic                  ew_en,
    input  logic                  ew_sel,
    input  logic [OFF_W-1:0]      ew_off,
    input  logic [7:0]            ew_data,
    input  logic                  aw_en,
    input  logic [PAGE_NUM_W-1:0] aw_page,
    input  logic [OFF_W-1:0]      aw_off,
    input  logic [7:0]            aw_data,
    input  logic                  hr_sel,
    input  logic [PAGE_NUM_W-1:0] hr_page,
    input  logic [OFF_W-1:0]      hr_off,
    output logic [7:0]            hr_bdata,
    output logic [7:0]            hr_adata,
    input  logic                  er_sel,
    input  logic [PAGE_NUM_W-1:0] er_page,
    input  logic [OFF_W-1:0]      er_off,
    output logic [7:0]            er_bdata,
    output logic [7:0]            er_adata
);
    logic [7:0] hr_b [2];
    logic [7:0] er_b [2];
    logic [7:0] arr  [NUM_PAGES * PAGE_BYTES];

    function automatic logic [AW-1:0] flat(input logic [PAGE_NUM_W-1:0] pg,
                                           input logic [OFF_W-1:0] off);
        return AW'(pg % NUM_PAGES) * AW'(PAGE_BYTES) + AW'(off);
    endfunction

    for (genvar b = 0; b < 2; b++) begin : g_buf
        logic [7:0] mem [PAGE_BYTES];
        always_ff @(posedge clk) begin
            if (ew_en && (ew_sel == 1'(b))) mem[ew_off] <= ew_data;
            if (hw_en && (hw_sel == 1'(b))) mem[hw_off] <= hw_data;
        end
        assign hr_b[b] = mem[hr_off];
        assign er_b[b] = mem[er_off];
    end

    always_ff @(posedge clk) begin
        if (aw_en) arr[flat(aw_page, aw_off)] <= aw_data;
    end

    assign hr_bdata = hr_b[hr_sel];
    assign er_bdata = er_b[er_sel];
    assign hr_adata = arr[flat(hr_page, hr_off)];
    assign er_adata = arr[flat(er_page, er_off)];
endmodule

// File: rtl/pflash_engine.sv
module pflash_engine #(
    parameter int PAGE_BYTES  = 264,
    parameter int PAGE_NUM_W  = 12,
    parameter int TAIL_CYCLES = 2000,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int TW         = $clog2(TAIL_CYCLES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  start_prog,
    input  logic                  start_sel,
    input  logic [PAGE_NUM_W-1:0] start_page,
    output logic                  busy,
    output logic                  ew_en,
    output logic                  ew_sel,
    output logic [OFF_W-1:0]      ew_off,
    output logic [7:0]            ew_data,
    output logic                  aw_en,
    output logic [PAGE_NUM_W-1:0] aw_page,
    output logic [OFF_W-1:0]      aw_off,
    output logic [7:0]            aw_data,
    output logic                  er_sel,
    output logic [PAGE_NUM_W-1:0] er_page,
    output logic [OFF_W-1:0]      er_off,
    input  logic [7:0]            er_bdata,
    input  logic [7:0]            er_adata
);
    typedef enum logic [1:0] {E_IDLE, E_COPY, E_TAIL} eng_state_t;

    eng_state_t           est, est_nxt;
    logic                 op_prog, sel_q;
    logic [PAGE_NUM_W-1:0] page_q;
    logic [OFF_W-1:0]     idx;
    logic [TW-1:0]        tail;

    always_comb begin
        est_nxt = est;
        unique case (est)
            E_IDLE: if (start) est_nxt = E_COPY;
            E_COPY: if (idx == OFF_W'(PAGE_BYTES - 1)) est_nxt = E_TAIL;
            E_TAIL: if (tail == TW'(TAIL_CYCLES - 1)) est_nxt = E_IDLE;
            default: est_nxt = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) est <= E_IDLE;
        else        est <= est_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_prog <= 1'b0;
            sel_q   <= 1'b0;
            page_q  <= '0;
            idx     <= '0;
            tail    <= '0;
        end else begin
            unique case (est)
                E_IDLE: if (start) begin
                    op_prog <= start_prog;
                    sel_q   <= start_sel;
                    page_q  <= start_page;
                    idx     <= '0;
                    tail    <= '0;
                end
                E_COPY: idx  <= idx + 1'b1;
                E_TAIL: tail <= tail + 1'b1;
                default: ;
            endcase
        end
    end

    assign busy    = (est != E_IDLE);
    assign er_sel  = sel_q;
    assign er_page = page_q;
    assign er_off  = idx;
    assign ew_en   = (est == E_COPY) && !op_prog;
    assign ew_sel  = sel_q;
    assign ew_off  = idx;
    assign ew_data = er_adata;
    assign aw_en   = (est == E_COPY) && op_prog;
    assign aw_page = page_q;
    assign aw_off  = idx;
    assign aw_data = er_bdata;
endmodule

// File: rtl/pflash_frontend.sv
module pflash_frontend
    import pflash_pkg::*;
#(
    parameter int PAGE_BYTES  = 264,
    parameter int NUM_PAGES   = 8,
    parameter int PAGE_NUM_W  = 12,
    parameter int ADDR_BITS   = 24,
    parameter int ARD_DUMMY   = 32,
    parameter int BRD_DUMMY   = 8,
    parameter int SYNC_STAGES = 2,
    parameter int TAIL_CYCLES = 2000,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int CNT_W      = $clog2(ADDR_BITS + ARD_DUMMY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic csn,
    input  logic si,
    output logic so,
    output logic rdy
);
    logic [2:0] s_lvl, s_rise, s_fall;
    logic sck_r, sck_f, csn_s, cs_r, si_s;

    pflash_sync #(.W(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in({si, csn, sck}),
        .sync_out(s_lvl), .rise(s_rise), .fall(s_fall)
    );
    assign sck_r = s_rise[0];
    assign sck_f = s_fall[0];
    assign csn_s = s_lvl[1];
    assign cs_r  = s_rise[1];
    assign si_s  = s_lvl[2];

    fe_state_t             state, nxt;
    cmd_kind_t             kind;
    logic                  bsel;
    logic [CNT_W-1:0]      cnt;
    logic [6:0]            opc_sr;
    logic [ADDR_BITS-2:0]  addr_sr;
    logic [OFF_W-1:0]      ptr;
    logic [PAGE_NUM_W-1:0] page_q;
    logic [2:0]            bitpos;
    logic [6:0]            in_sr;
    logic                  so_q, so_oe;
    logic                  eng_start, eng_busy;

    logic [7:0]            opcode_full;
    logic [ADDR_BITS-1:0]  addr_full;
    cmd_t                  dec;
    logic [CNT_W-1:0]      dummy_last;
    logic [7:0]            out_byte;
    logic                  hw_en;
    logic [7:0]            hr_bdata, hr_adata;

    logic                  ew_en, ew_sel, aw_en, er_sel;
    logic [OFF_W-1:0]      ew_off, aw_off, er_off;
    logic [7:0]            ew_data, aw_data, er_bdata, er_adata;
    logic [PAGE_NUM_W-1:0] aw_page, er_page;

    assign opcode_full = {opc_sr, si_s};
    assign addr_full   = {addr_sr, si_s};
    assign dec         = decode_op(opcode_full);
    assign dummy_last  = (kind == K_ARD) ? CNT_W'(ARD_DUMMY - 1) : CNT_W'(BRD_DUMMY - 1);

    function automatic logic [OFF_W-1:0] wrap_next(input logic [OFF_W-1:0] p);
        return (p == OFF_W'(PAGE_BYTES - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [OFF_W-1:0] norm_off(input logic [OFF_W-1:0] p);
        return (p >= OFF_W'(PAGE_BYTES)) ? p - OFF_W'(PAGE_BYTES) : p;
    endfunction

    always_comb begin
        unique case (kind)
            K_STAT:  out_byte = status_byte(!eng_busy);
            K_ARD:   out_byte = hr_adata;
            default: out_byte = hr_bdata;
        endcase
    end

    // next state
    always_comb begin
        nxt = state;
        if (csn_s) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_OPC;
                ST_OPC: if (sck_r && cnt == CNT_W'(7)) begin
                    if (dec.kind == K_NONE || (needs_array(dec.kind) && eng_busy))
                        nxt = ST_SKIP;
                    else if (dec.kind == K_STAT)
                        nxt = ST_OUT;
                    else
                        nxt = ST_ADDR;
                end
                ST_ADDR: if (sck_r && cnt == CNT_W'(ADDR_BITS - 1)) begin
                    unique case (kind)
                        K_ARD, K_BRD: nxt = ST_DUMMY;
                        K_BWR:        nxt = ST_IN;
                        default:      nxt = ST_HOLD;
                    endcase
                end
                ST_DUMMY: if (sck_r && cnt == dummy_last) nxt = ST_OUT;
                ST_OUT, ST_IN, ST_HOLD, ST_SKIP: nxt = state;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind      <= K_NONE;
            bsel      <= 1'b0;
            cnt       <= '0;
            opc_sr    <= '0;
            addr_sr   <= '0;
            ptr       <= '0;
            page_q    <= '0;
            bitpos    <= '0;
            in_sr     <= '0;
            so_q      <= 1'b0;
            so_oe     <= 1'b0;
            eng_start <= 1'b0;
        end else begin
            eng_start <= cs_r && (state == ST_HOLD) && !eng_busy;
            if (csn_s) begin
                so_oe <= 1'b0;
                cnt   <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: cnt <= '0;
                    ST_OPC: if (sck_r) begin
                        opc_sr <= opcode_full[6:0];
                        if (cnt == CNT_W'(7)) begin
                            cnt    <= '0;
                            kind   <= dec.kind;
                            bsel   <= dec.bsel;
                            bitpos <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_ADDR: if (sck_r) begin
                        addr_sr <= addr_full[ADDR_BITS-2:0];
                        if (cnt == CNT_W'(ADDR_BITS - 1)) begin
                            cnt    <= '0;
                            ptr    <= norm_off(addr_full[OFF_W-1:0]);
                            page_q <= addr_full[OFF_W +: PAGE_NUM_W];
                            bitpos <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DUMMY: if (sck_r) begin
                        cnt <= (cnt == dummy_last) ? '0 : cnt + 1'b1;
                    end
                    ST_OUT: begin
                        if (sck_f) begin
                            so_q  <= out_byte[3'd7 - bitpos];
                            so_oe <= 1'b1;
                        end
                        if (sck_r) begin
                            bitpos <= bitpos + 3'd1;
                            if (bitpos == 3'd7 && kind != K_STAT) ptr <= wrap_next(ptr);
                        end
                    end
                    ST_IN: if (sck_r) begin
                        in_sr  <= {in_sr[5:0], si_s};
                        bitpos <= bitpos + 3'd1;
                        if (bitpos == 3'd7) ptr <= wrap_next(ptr);
                    end
                    ST_HOLD, ST_SKIP: ;
                    default: ;
                endcase
            end
        end
    end

    assign hw_en = !csn_s && (state == ST_IN) && sck_r && (bitpos == 3'd7);

    pflash_store #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES), .PAGE_NUM_W(PAGE_NUM_W)) u_store (
        .clk(clk),
        .hw_en(hw_en), .hw_sel(bsel), .hw_off(ptr), .hw_data({in_sr, si_s}),
        .ew_en(ew_en), .ew_sel(ew_sel), .ew_off(ew_off), .ew_data(ew_data),
        .aw_en(aw_en), .aw_page(aw_page), .aw_off(aw_off), .aw_data(aw_data),
        .hr_sel(bsel), .hr_page(page_q), .hr_off(ptr),
        .hr_bdata(hr_bdata), .hr_adata(hr_adata),
        .er_sel(er_sel), .er_page(er_page), .er_off(er_off),
        .er_bdata(er_bdata), .er_adata(er_adata)
    );

    pflash_engine #(.PAGE_BYTES(PAGE_BYTES), .PAGE_NUM_W(PAGE_NUM_W), .TAIL_CYCLES(TAIL_CYCLES)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .start(eng_start), .start_prog(kind == K_PROG), .start_sel(bsel), .start_page(page_q),
        .busy(eng_busy),
        .ew_en(ew_en), .ew_sel(ew_sel), .ew_off(ew_off), .ew_data(ew_data),
        .aw_en(aw_en), .aw_page(aw_page), .aw_off(aw_off), .aw_data(aw_data),
        .er_sel(er_sel), .er_page(er_page), .er_off(er_off),
        .er_bdata(er_bdata), .er_adata(er_adata)
    );

    assign so  = so_oe ? so_q : 1'bz;
    assign rdy = !eng_busy;
endmodule

// File: rtl/pflash_frontend_chk.sv
module pflash_frontend_chk
    import pflash_pkg::*;
#(
    parameter int PAGE_BYTES  = 264,
    parameter int TAIL_CYCLES = 2000,
    localparam int OFF_W      = $clog2(PAGE_BYTES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             csn_s,
    input logic             cs_r,
    input logic             sck_f,
    input logic             so_oe,
    input logic             so_q,
    input logic             eng_busy,
    input fe_state_t        state_q,
    input logic [OFF_W-1:0] ptr
);
    int busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_run <= 0;
        else        busy_run <= eng_busy ? busy_run + 1 : 0;
    end

    assert_so_moves_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && (so_q != $past(so_q))) |-> $past(sck_f));

    assert_hiz_after_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csn_s) |=> !so_oe);

    assert_ptr_in_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ptr < OFF_W'(PAGE_BYTES));

    assert_launch_on_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_busy) |-> $past(cs_r, 2));

    assert_skip_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> !so_oe);

    assert_busy_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= PAGE_BYTES + TAIL_CYCLES + 4);
endmodule

bind pflash_frontend pflash_frontend_chk #(.PAGE_BYTES(PAGE_BYTES), .TAIL_CYCLES(TAIL_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .cs_r(cs_r), .sck_f(sck_f),
    .so_oe(so_oe), .so_q(so_q), .eng_busy(eng_busy), .state_q(state), .ptr(ptr)
);

// File: tb/pflash_frontend_test.sv
`timescale 1ns/1ps
module pflash_frontend_test;
    localparam int H = 40;

    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, csn = 1'b1, si = 1'b0;
    wire  so;
    logic rdy;

    always #2 clk = ~clk;

    pflash_frontend #(.TAIL_CYCLES(6000)) uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .si(si), .so(so), .rdy(rdy)
    );

    int checks = 0, fails = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] wr_q[$];
    logic       mon_on = 1'b0;
    logic [7:0] mon_sr = '0;
    int         mon_n = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic expect_byte(input logic [7:0] v, input string req);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    // scoreboard monitor: pops one expected byte per received byte
    always @(posedge sck) begin
        if (mon_on) begin
            mon_sr = {mon_sr[6:0], so};
            mon_n++;
            if (mon_n == 8) begin
                mon_n = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "SCOREBOARD", "unexpected byte", {24'h0, mon_sr}, 32'h0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(mon_sr === e, t, "read byte", {24'h0, mon_sr}, {24'h0, e});
                end
            end
        end
    end

    task automatic shift_bit(input logic b);
        sck = 1'b0; si = b; #H;
        sck = 1'b1; #H;
    endtask

    task automatic shift_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) shift_bit(v[i]);
    endtask

    task automatic shift_addr(input logic [23:0] a);
        for (int i = 23; i >= 0; i--) shift_bit(a[i]);
    endtask

    task automatic cs_open(input bit m3);
        sck = m3; #H;
        csn = 1'b0; #H;
    endtask

    task automatic cs_close(input bit m3);
        mon_on = 1'b0;
        mon_n  = 0;
        if (!m3) sck = 1'b0;
        #H;
        csn = 1'b1;
        #(H * 3);
    endtask

    task automatic read_cmd(input bit m3, input logic [7:0] op, input logic [23:0] a,
                            input int dummy, input int nbytes);
        cs_open(m3);
        shift_byte(op);
        shift_addr(a);
        for (int i = 0; i < dummy; i++) shift_bit(1'b0);
        mon_on = 1'b1;
        for (int i = 0; i < nbytes; i++) shift_byte(8'h00);
        cs_close(m3);
    endtask

    task automatic write_cmd(input bit m3, input logic [7:0] op, input logic [23:0] a,
                             input int extra_bits);
        cs_open(m3);
        shift_byte(op);
        shift_addr(a);
        while (wr_q.size() > 0) shift_byte(wr_q.pop_front());
        for (int i = 0; i < extra_bits; i++) shift_bit(1'b1);
        cs_close(m3);
    endtask

    task automatic short_cmd(input logic [7:0] op, input logic [23:0] a);
        cs_open(1'b0);
        shift_byte(op);
        shift_addr(a);
        cs_close(1'b0);
    endtask

    task automatic status_cmd(input int nbytes);
        cs_open(1'b0);
        shift_byte(8'h57);
        mon_on = 1'b1;
        for (int i = 0; i < nbytes; i++) shift_byte(8'h00);
        cs_close(1'b0);
    endtask

    task automatic drained(input string req);
        check(exp_q.size() == 0, req, "bytes still expected", exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic wait_ready(input string req);
        int n = 0;
        while (!rdy && n < 20000) begin #H; n++; end
        check(rdy === 1'b1, req, "ready after operation", {31'h0, rdy}, 32'h1);
    endtask

    function automatic logic [23:0] arr_addr(input int page, input int off);
        return 24'((page << 9) | off);
    endfunction

    initial begin : watchdog
        #700_000;
        checks++;
        fails++;
        $display("FAIL WATCHDOG run did not finish actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        #100 rst_n = 1'b1;
        #200;
        // R11 reset state
        check(rdy === 1'b1, "R11", "rdy after reset", {31'h0, rdy}, 32'h1);
        check(so === 1'bz, "R11", "so after reset", {31'h0, so}, 32'h0);

        // R4 write buffer 0: byte at 8 first, then 0..7 plus a partial byte
        wr_q.push_back(8'h5A);
        write_cmd(1'b0, 8'h84, 24'd8, 0);
        for (int i = 0; i < 8; i++) wr_q.push_back(8'h11 + 8'(i));
        write_cmd(1'b0, 8'h84, 24'd0, 4);
        for (int i = 0; i < 8; i++) expect_byte(8'h11 + 8'(i), "R4");
        expect_byte(8'h5A, "R4_partial");
        read_cmd(1'b0, 8'h54, 24'd0, 8, 9);
        drained("R3");
        check(so === 1'bz, "R7", "so after read deselect", {31'h0, so}, 32'h0);

        // R1 / R3 mode 3 buffer read at offset 2
        expect_byte(8'h13, "R1_mode3");
        expect_byte(8'h14, "R3");
        read_cmd(1'b1, 8'h54, 24'd2, 8, 2);
        drained("R1");

        // R5 wrap in buffer 1
        for (int i = 0; i < 4; i++) wr_q.push_back(8'hA1 + 8'(i));
        write_cmd(1'b0, 8'h87, 24'd262, 0);
        for (int i = 0; i < 4; i++) expect_byte(8'hA1 + 8'(i), "R5_wrap");
        read_cmd(1'b0, 8'h56, 24'd262, 8, 4);
        drained("R5");
        expect_byte(8'hA3, "R5_start0");
        expect_byte(8'hA4, "R5_start0");
        read_cmd(1'b0, 8'h56, 24'd0, 8, 2);
        expect_byte(8'hA3, "R5_off264");
        read_cmd(1'b0, 8'h56, 24'd264, 8, 1);
        drained("R5");

        // R6 idle status repeats
        expect_byte(8'hA0, "R6");
        expect_byte(8'hA0, "R6_repeat");
        status_cmd(2);
        drained("R6");

        // R9 program buffer 0 into page 3
        short_cmd(8'h83, arr_addr(3, 0));
        #(H * 2);
        check(rdy === 1'b0, "R8", "rdy low while busy", {31'h0, rdy}, 32'h0);
        expect_byte(8'h20, "R6_busy");
        status_cmd(1);
        drained("R6");

        // R10 array read while busy stays silent
        begin
            bit quiet = 1'b1;
            cs_open(1'b0);
            shift_byte(8'h52);
            shift_addr(arr_addr(3, 0));
            for (int i = 0; i < 48; i++) begin
                shift_bit(1'b0);
                if (so !== 1'bz) quiet = 1'b0;
            end
            cs_close(1'b0);
            check(quiet, "R10", "array read while busy drove so", {31'h0, quiet}, 32'h1);
        end
        // R10 copy while busy must not launch; buffer write still works
        short_cmd(8'h55, arr_addr(5, 0));
        wr_q.push_back(8'hC1);
        wr_q.push_back(8'hC2);
        write_cmd(1'b0, 8'h87, 24'd10, 0);

        // R6 live status: one long read sees busy turn to ready
        begin
            logic [7:0] b;
            bit seen = 1'b0;
            cs_open(1'b0);
            shift_byte(8'h57);
            for (int k = 0; k < 80 && !seen; k++) begin
                for (int i = 0; i < 8; i++) begin
                    sck = 1'b0; #H;
                    sck = 1'b1;
                    b = {b[6:0], so};
                    #H;
                end
                if (k == 0) check(b === 8'h20, "R6", "first pass while busy", {24'h0, b}, 32'h20);
                if (b === 8'hA0) seen = 1'b1;
            end
            cs_close(1'b0);
            check(seen, "R6", "live status reached ready", {31'h0, seen}, 32'h1);
        end
        wait_ready("R8");

        expect_byte(8'hC1, "R10_bufwrite");
        expect_byte(8'hC2, "R10_nolaunch");
        read_cmd(1'b0, 8'h56, 24'd10, 8, 2);
        drained("R10");

        // R2 / R9 array read of page 3
        for (int i = 0; i < 8; i++) expect_byte(8'h11 + 8'(i), "R9");
        expect_byte(8'h5A, "R2");
        read_cmd(1'b0, 8'h52, arr_addr(3, 0), 32, 9);
        drained("R2");

        // R8 copy page 3 into buffer 1
        short_cmd(8'h55, arr_addr(3, 0));
        #(H * 2);
        check(rdy === 1'b0, "R8", "rdy low during copy", {31'h0, rdy}, 32'h0);
        wait_ready("R8");
        expect_byte(8'h11, "R8");
        expect_byte(8'h12, "R8");
        read_cmd(1'b0, 8'h56, 24'd0, 8, 2);
        drained("R8");

        // R1 unknown command stays silent, then a status read works
        begin
            bit quiet = 1'b1;
            cs_open(1'b0);
            shift_byte(8'hA5);
            for (int i = 0; i < 24; i++) begin
                shift_bit(1'b1);
                if (so !== 1'bz) quiet = 1'b0;
            end
            cs_close(1'b0);
            check(quiet, "R1", "unknown command drove so", {31'h0, quiet}, 32'h1);
        end
        expect_byte(8'hA0, "R1_recover");
        status_cmd(1);
        drained("R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule